// File: doc/BRIEF.md
# DMA Channel Control and Status Block

This block is the control and status logic of a single DMA channel. Software reaches it through a simple register write/read port that exposes two words: a 32-bit mode word and a status word. The block decides when the transfer engine is started or aborted and when the channel counts as idle. It gathers completion and error pulses from the engine into sticky event bits and drives one interrupt line.

A transfer can begin in one of two ways. In the first, software raises the start bit and the transfer begins at once. In the second, software raises the external-start enable, which arms the channel; the transfer then begins when the external start pin is seen high. Abort is a two-write sequence: first a write that sets the abort bit, then a write that clears abort, start and external-start. The channel is idle and halted one clock after the first write.

If a transfer is started while the byte count is zero, no data moves and a programming-error event is recorded instead. Event bits clear when software writes ones to them. The busy and halted bits are live conditions: software cannot clear them and they never raise the interrupt.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, and after any write of the all-zero value to the mode word, the mode word, all event bits, busy, halted and irq are 0. A zero write also drops an armed external start, and it overrides an event that arrives in the same cycle.
- R2: A mode write that raises bit 0 (start) from 0 to 1, with bit 2 (external-start enable) 0, bit 1 (abort) 0, the channel not busy and a nonzero byte count, pulses eng_start for exactly one cycle after that edge and sets busy (status bit 5).
- R3: A mode write that raises bit 0 or bit 2 while bit 2 is 1 only arms the channel. eng_start pulses on the edge that follows a cycle in which the channel is armed and ext_start is high, and busy is set at that edge.
- R4: When a transfer would begin while byte_cnt is zero, eng_start stays low, busy stays 0 and the programming-error event (status bit 1) is set.
- R5: A mode write that raises bit 1 (abort) pulses eng_abort for one cycle, clears busy and any armed start, and sets halted (status bit 6). A later write that clears the abort bit leaves halted set. Halted clears when the next transfer begins.
- R6: The end-of-links, end-of-chained-descriptor and transfer-error pulses each clear busy. The channel is idle when busy is 0 or halted is 1.
- R7: The engine pulses set these status event bits: transfer error at bit 0, end of segment at bit 2, end of chained descriptor at bit 3, and end of links list at bit 4.
- R8: A status write clears every event bit in bits 4..0 where the written data has a one and leaves the other event bits unchanged. Writing back the value just read clears exactly the events that were observed. Busy and halted are not affected by status writes.
- R9: If an event pulse arrives in the same cycle as a status write that clears the same bit, the bit stays set.
- R10: irq is high exactly when an event bit is set and its enable is set. Mode bit 3 enables bits 0 and 1, mode bit 4 enables bit 2, and mode bit 5 enables bits 3 and 4. Busy and halted never drive irq. irq changes on the same edge as the status bits.
- R11: rd_data shows, one cycle later, the mode word when rd_sel is 0 and the status word when rd_sel is 1. Both words are sampled as they stood before that edge. Status bits above 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode word, 1 status word |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read source: 0 mode word, 1 status word |
| rd_data | output | DATA_W | Registered read data |
| byte_cnt | input | CNT_W | Current byte count from the engine |
| ext_start | input | 1 | External start pin |
| ev_seg | input | 1 | End-of-segment pulse |
| ev_list | input | 1 | End-of-links-list pulse |
| ev_chain | input | 1 | End-of-chained-descriptor pulse |
| ev_err | input | 1 | Transfer error pulse |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_abort | output | 1 | One-cycle abort strobe to the engine |
| irq | output | 1 | Channel interrupt |

## Verification
The start logic is driven through a software start, an armed start that waits several cycles for the pin, a start with a zero byte count, and a start after an abort. Between them these separate an immediate start from an armed one, and a real start from a programming error, and they show that halted is released only by a new transfer. Events are raised alone, with their interrupt enable off and later switched on, and in the same cycle as a clear of the same bit. This tells the masking of irq apart from the event storage, and shows that a new event beats a clear. A behavioural model checks the strobes, irq and read data on every clock.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // mode word bit positions
  localparam int MB_START  = 0;
  localparam int MB_ABORT  = 1;
  localparam int MB_EXT    = 2;
  localparam int MB_IE_ERR = 3;
  localparam int MB_IE_SEG = 4;
  localparam int MB_IE_LNK = 5;
  localparam int NUM_EN    = 3;

  // status word: events in bits 4..0, then live bits
  localparam int NUM_EV    = 5;
  localparam int SB_BUSY   = 5;
  localparam int SB_HALT   = 6;
  localparam int STAT_W    = 7;

  typedef struct packed {
    logic link;
    logic chain;
    logic seg;
    logic perr;
    logic terr;
  } chan_ev_t;

  // which enable (0 err, 1 seg, 2 link) governs each event bit
  function automatic int ev_group(input int idx);
    if (idx <= 1)      return 0;
    else if (idx == 2) return 1;
    else               return 2;
  endfunction
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mode_q,
  output logic              soft_reset,
  output logic              req_start,
  output logic              req_ext,
  output logic              req_abort
);
  logic cs_rise, es_rise;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= wr_data;
  end

  assign soft_reset = wr_mode && (wr_data == '0);
  assign cs_rise    = wr_data[MB_START] && !mode_q[MB_START];
  assign es_rise    = wr_data[MB_EXT]   && !mode_q[MB_EXT];
  assign req_abort  = wr_mode && wr_data[MB_ABORT] && !mode_q[MB_ABORT];
  assign req_start  = wr_mode && !wr_data[MB_ABORT] && (cs_rise || es_rise);
  assign req_ext    = wr_data[MB_EXT];
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_reset,
  input  logic             req_start,
  input  logic             req_ext,
  input  logic             req_abort,
  input  logic             ext_start,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             done_any,
  output logic             busy_q,
  output logic             halt_q,
  output logic             start_q,
  output logic             abort_q,
  output logic             perr_pulse
);
  logic armed_q;
  logic busy_d, halt_d, armed_d, start_d, abort_d, go;

  always_comb begin
    busy_d     = busy_q;
    halt_d     = halt_q;
    armed_d    = armed_q;
    start_d    = 1'b0;
    abort_d    = 1'b0;
    perr_pulse = 1'b0;
    go         = 1'b0;
    if (done_any) busy_d = 1'b0;
    if (soft_reset) begin
      busy_d  = 1'b0;
      halt_d  = 1'b0;
      armed_d = 1'b0;
    end else if (req_abort) begin
      abort_d = 1'b1;
      busy_d  = 1'b0;
      armed_d = 1'b0;
      halt_d  = 1'b1;
    end else begin
      if (req_start && !busy_q) begin
        if (req_ext) armed_d = 1'b1;
        else         go      = 1'b1;
      end else if (armed_q && ext_start) begin
        armed_d = 1'b0;
        go      = 1'b1;
      end
      if (go) begin
        if (byte_cnt == '0) begin
          perr_pulse = 1'b1;
        end else begin
          start_d = 1'b1;
          busy_d  = 1'b1;
          halt_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      halt_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      halt_q  <= halt_d;
      armed_q <= armed_d;
      start_q <= start_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/dma_evt_stat.sv
module dma_evt_stat
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_reset,
  input  chan_ev_t          ev_in,
  input  logic              clr_en,
  input  logic [NUM_EV-1:0] clr_mask,
  input  logic [NUM_EN-1:0] en_nxt,
  output logic [NUM_EV-1:0] ev_q,
  output logic              irq_q
);
  logic [NUM_EV-1:0] ev_d, gated;

  always_comb begin
    if (soft_reset) ev_d = '0;
    else            ev_d = (ev_q & ~(clr_en ? clr_mask : '0)) | NUM_EV'(ev_in);
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_gate
    assign gated[i] = ev_d[i] && en_nxt[ev_group(i)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      irq_q <= |gated;
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              ext_start,
  input  logic              ev_seg,
  input  logic              ev_list,
  input  logic              ev_chain,
  input  logic              ev_err,
  output logic              eng_start,
  output logic              eng_abort,
  output logic              irq
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic              wr_mode, wr_stat;
  logic [DATA_W-1:0] mode_q;
  logic              soft_reset, req_start, req_ext, req_abort;
  logic              busy_q, halt_q, perr_pulse;
  logic [NUM_EV-1:0] ev_q;
  logic [NUM_EN-1:0] en_nxt;
  logic [DATA_W-1:0] stat_word;
  chan_ev_t          ev_in;

  assign wr_mode = wr_en && !wr_sel;
  assign wr_stat = wr_en && wr_sel;

  dma_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_data(wr_data),
    .mode_q(mode_q), .soft_reset(soft_reset), .req_start(req_start),
    .req_ext(req_ext), .req_abort(req_abort)
  );

  dma_chan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .soft_reset(soft_reset), .req_start(req_start),
    .req_ext(req_ext), .req_abort(req_abort), .ext_start(ext_start),
    .byte_cnt(byte_cnt), .done_any(ev_list || ev_chain || ev_err),
    .busy_q(busy_q), .halt_q(halt_q), .start_q(eng_start),
    .abort_q(eng_abort), .perr_pulse(perr_pulse)
  );

  assign ev_in = '{link: ev_list, chain: ev_chain, seg: ev_seg,
                   perr: perr_pulse, terr: ev_err};
  assign en_nxt = wr_mode ? wr_data[MB_IE_LNK:MB_IE_ERR]
                          : mode_q[MB_IE_LNK:MB_IE_ERR];

  dma_evt_stat u_evt (
    .clk(clk), .rst(rst), .soft_reset(soft_reset), .ev_in(ev_in),
    .clr_en(wr_stat), .clr_mask(wr_data[NUM_EV-1:0]), .en_nxt(en_nxt),
    .ev_q(ev_q), .irq_q(irq)
  );

  assign stat_word = {{PAD_W{1'b0}}, halt_q, busy_q, ev_q};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? stat_word : mode_q;
  end
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic              ev_seg,
  input logic              ev_list,
  input logic              eng_start,
  input logic              eng_abort,
  input logic              irq,
  input logic              busy_q,
  input logic              halt_q,
  input logic [4:0]        ev_q
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy_q);
  // R4
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> ($past(byte_cnt) != '0));
  // R5
  abort_halt_chk: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> (halt_q && !busy_q));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(eng_start && eng_abort));
  // R6
  list_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_list && busy_q) |=> !busy_q);
  // R8
  w1c_link_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[4] && !ev_list) |=> !ev_q[4]);
  // R9
  evt_win_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[2] && ev_seg) |=> ev_q[2]);
  // R10
  no_evt_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_q == 5'd0) |-> !irq);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .byte_cnt(byte_cnt), .ev_seg(ev_seg), .ev_list(ev_list),
  .eng_start(eng_start), .eng_abort(eng_abort), .irq(irq),
  .busy_q(busy_q), .halt_q(halt_q), .ev_q(ev_q)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  localparam int DW = 32;
  localparam int CW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, ext_start = 0;
  logic ev_seg = 0, ev_list = 0, ev_chain = 0, ev_err = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [DW-1:0] rd_data;
  logic eng_start, eng_abort, irq;

  always #2 clk = ~clk;

  dma_chan_ctl #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .byte_cnt(byte_cnt),
    .ext_start(ext_start), .ev_seg(ev_seg), .ev_list(ev_list),
    .ev_chain(ev_chain), .ev_err(ev_err), .eng_start(eng_start),
    .eng_abort(eng_abort), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [DW-1:0] m_mode;
  logic [4:0]    m_ev;
  bit m_busy, m_halt, m_armed;
  bit e_start, e_abort, e_irq;
  logic [DW-1:0] e_rd;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit mw, sw, zero, b0, want, go, pe;
    logic [DW-1:0] old;
    e_rd = rd_sel ? {25'd0, m_halt, m_busy, m_ev} : m_mode;
    e_start = 0; e_abort = 0; pe = 0; go = 0; zero = 0;
    if (rst) begin
      m_mode = '0; m_ev = '0; m_busy = 0; m_halt = 0; m_armed = 0;
      e_rd = '0; e_irq = 0;
      return;
    end
    mw = wr_en && !wr_sel;
    sw = wr_en && wr_sel;
    old = m_mode;
    b0 = m_busy;
    if (mw) m_mode = wr_data;
    if (ev_list || ev_chain || ev_err) m_busy = 0;
    if (mw && wr_data == '0) begin
      zero = 1; m_busy = 0; m_halt = 0; m_armed = 0;
    end else if (mw && wr_data[1] && !old[1]) begin
      e_abort = 1; m_busy = 0; m_armed = 0; m_halt = 1;
    end else begin
      want = mw && !wr_data[1] &&
             ((wr_data[0] && !old[0]) || (wr_data[2] && !old[2]));
      if (want && !b0) begin
        if (wr_data[2]) m_armed = 1; else go = 1;
      end else if (m_armed && ext_start) begin
        m_armed = 0; go = 1;
      end
      if (go) begin
        if (byte_cnt == '0) pe = 1;
        else begin e_start = 1; m_busy = 1; m_halt = 0; end
      end
    end
    if (zero) m_ev = '0;
    else begin
      if (sw) m_ev = m_ev & ~wr_data[4:0];
      m_ev = m_ev | {ev_list, ev_chain, ev_seg, pe, ev_err};
    end
    e_irq = ((m_ev[0] || m_ev[1]) && m_mode[3]) || (m_ev[2] && m_mode[4]) ||
            ((m_ev[3] || m_ev[4]) && m_mode[5]);
  endtask

  // one clock: update model from current inputs, compare after the edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R2 eng_start", DW'(eng_start), DW'(e_start));
    check("R5 eng_abort", DW'(eng_abort), DW'(e_abort));
    check("R10 irq", DW'(irq), DW'(e_irq));
    check("R11 rd_data", rd_data, e_rd);
  endtask

  task automatic wr_mode(input logic [DW-1:0] v);
    wr_en = 1; wr_sel = 0; wr_data = v; tick(); wr_en = 0; wr_data = '0;
  endtask

  task automatic wr_stat(input logic [DW-1:0] v);
    wr_en = 1; wr_sel = 1; wr_data = v; tick(); wr_en = 0; wr_data = '0;
  endtask

  task automatic read_reg(input logic sel, output logic [DW-1:0] v);
    rd_sel = sel; tick(); v = rd_data;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ev_err = 1;
      1: ev_seg = 1;
      2: ev_chain = 1;
      default: ev_list = 1;
    endcase
    tick();
    ev_err = 0; ev_seg = 0; ev_chain = 0; ev_list = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R1 reset state
    read_reg(0, v); check("R1 mode after reset", v, 32'h0);
    read_reg(1, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", DW'(irq), 32'h0);

    // R2 software start
    byte_cnt = 100;
    wr_mode(32'h39);
    read_reg(1, v); check("R2 busy after start", v, 32'h20);

    // R7 segment event, R10 enabled irq
    pulse(1);
    read_reg(1, v); check("R7 seg event", v, 32'h24);
    check("R10 irq with seg enabled", DW'(irq), 32'h1);

    // R8 clear one bit
    wr_stat(32'h04);
    read_reg(1, v); check("R8 seg cleared", v, 32'h20);

    // R6 end of links clears busy
    pulse(3);
    read_reg(1, v); check("R6 links done idle", v, 32'h10);

    // R8 write back what was read
    wr_stat(v);
    read_reg(1, v); check("R8 write-back clears", v, 32'h0);

    // R9 event beats clear
    ev_seg = 1; wr_stat(32'h04); ev_seg = 0;
    read_reg(1, v); check("R9 event wins", v, 32'h04);
    wr_stat(32'h04);

    // R4 zero byte count
    wr_mode(32'h38);
    byte_cnt = 0;
    wr_mode(32'h39);
    read_reg(1, v); check("R4 prog error no busy", v, 32'h02);
    check("R4 prog error irq", DW'(irq), 32'h1);
    wr_stat(32'h02);

    // R10 masked event, then enable
    wr_mode(32'h80);
    pulse(0);
    check("R10 masked error no irq", DW'(irq), 32'h0);
    wr_mode(32'h88);
    check("R10 enable raises irq", DW'(irq), 32'h1);
    wr_stat(32'h01);

    // R3 external start
    byte_cnt = 50;
    wr_mode(32'h04);
    tick(); tick(); tick();
    read_reg(1, v); check("R3 armed not busy", v, 32'h0);
    ext_start = 1; tick(); ext_start = 0;
    check("R3 pin starts", DW'(eng_start), 32'h1);
    read_reg(1, v); check("R3 busy after pin", v, 32'h20);

    // R5 abort sequence
    wr_mode(32'h06);
    read_reg(1, v); check("R5 halted after abort", v, 32'h40);
    wr_mode(32'h08);
    read_reg(1, v); check("R5 halted kept", v, 32'h40);
    wr_mode(32'h09);
    read_reg(1, v); check("R5 restart clears halt", v, 32'h20);

    // R6 chained descriptor end
    pulse(2);
    read_reg(1, v); check("R6 chain done idle", v, 32'h08);
    wr_stat(32'h08);

    // R6 transfer error ends transfer
    wr_mode(32'h08);
    wr_mode(32'h09);
    pulse(0);
    read_reg(1, v); check("R6 error idle", v, 32'h01);

    // R1 zero write resets
    wr_mode(32'h0);
    read_reg(1, v); check("R1 zero write status", v, 32'h0);
    read_reg(0, v); check("R1 zero write mode", v, 32'h0);

    // R11 mode readback
    wr_mode(32'h12345638);
    read_reg(0, v); check("R11 mode readback", v, 32'h12345638);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule